// File: doc/BRIEF.md
# Bit-Slice Arithmetic and Logic Unit

This block is a combinational arithmetic and logic unit for a 32-bit datapath. It is assembled from identical one-bit slices, each holding an AND gate, an OR gate and a full adder, with a small multiplexer that picks the slice output. A two-bit function select is wired unchanged to every slice, and one negate line both inverts the B operand inside every slice and supplies the carry into bit 0. Together they give bitwise AND, bitwise OR, addition, subtraction and a signed less-than compare.

The compare reuses the subtraction path. Bit 0 of the result takes the sign of A minus B, flipped when that subtraction overflows. Every other result bit is forced low. A zero flag, a signed overflow flag and the carry out of the top slice come with every result. The flags always describe the adder path, so they only carry meaning for add and subtract.

The control word is {neg_b, func_sel}. It is used by the instruction decode stage of a simple processor core.

Top module: `slice_alu`

## Requirements
- R1: With control {neg_b, func_sel} = 0_00, result equals opnd_a AND opnd_b, bit by bit.
- R2: With control 0_01, result equals opnd_a OR opnd_b, bit by bit.
- R3: With control 0_10, result equals opnd_a + opnd_b modulo 2^32, and carry_out equals bit 32 of the unsigned 33-bit sum.
- R4: With control 1_10, result equals opnd_a - opnd_b modulo 2^32, and carry_out equals bit 32 of opnd_a + ~opnd_b + 1 (high when opnd_a >= opnd_b taken as unsigned).
- R5: With control 1_11, result bit 0 is 1 exactly when opnd_a < opnd_b as signed two's complement values, and result bits 31..1 are 0. This holds when A - B overflows, including for the most negative value.
- R6: zero is 1 exactly when all 32 result bits are 0, under every control code.
- R7: Under 0_10 and 1_10, overflow is 1 exactly when the signed result is out of range. For add this means the operand signs agree and the result sign differs. For subtract it means the operand signs differ and the result sign differs from opnd_a.
- R8: Under the logical codes 0_00 and 0_01, carry_out and overflow still come from the adder path computing opnd_a + opnd_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| neg_b | input | 1 | Inverts B in every slice and sets the carry into bit 0 |
| func_sel | input | 2 | Slice output select: 00 AND, 01 OR, 10 sum, 11 less-than |
| result | output | 32 | Selected result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of the adder path |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
The assertions sample the unit once its inputs have settled. They assume that neg_b and func_sel hold one of the five defined codes whenever the arithmetic and compare properties are evaluated. The bench only drives those five codes, and it waits one time step after each change before it samples. The properties for each function are therefore guarded by their own code, while the zero flag property is checked for every input.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_SUM  = 2'b10,
        FN_LESS = 2'b11
    } alu_fn_e;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import slice_alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       b_inv,
    input  logic       c_in,
    input  logic       less_in,
    input  logic [1:0] fn,
    output logic       res_bit,
    output logic       sum_bit,
    output logic       c_out
);

    logic b_eff;
    logic half;

    always_comb begin
        b_eff   = b_bit ^ b_inv;
        half    = a_bit ^ b_eff;
        sum_bit = half ^ c_in;
        c_out   = (a_bit & b_eff) | (half & c_in);
    end

    always_comb begin
        unique case (alu_fn_e'(fn))
            FN_AND:  res_bit = a_bit & b_eff;
            FN_OR:   res_bit = a_bit | b_eff;
            FN_SUM:  res_bit = sum_bit;
            FN_LESS: res_bit = less_in;
            default: res_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_sign_fix.sv
module alu_sign_fix (
    input  logic msb_sum,
    input  logic msb_c_in,
    input  logic msb_c_out,
    output logic ovf,
    output logic less_out
);

    always_comb begin
        ovf      = msb_c_in ^ msb_c_out;
        less_out = msb_sum ^ ovf;
    end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec,
    output logic             all_zero
);

    always_comb all_zero = ~(|vec);

endmodule

// File: rtl/slice_alu.sv
module slice_alu #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             neg_b,
    input  logic [1:0]       func_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow,
    output logic             carry_out
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sums;
    logic             set_bit;

    assign carry[0] = neg_b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_i;
        if (i == 0) begin : g_lsb
            assign less_i = set_bit;
        end else begin : g_upper
            assign less_i = 1'b0;
        end
        alu_bit_slice u_slice (
            .a_bit   (opnd_a[i]),
            .b_bit   (opnd_b[i]),
            .b_inv   (neg_b),
            .c_in    (carry[i]),
            .less_in (less_i),
            .fn      (func_sel),
            .res_bit (result[i]),
            .sum_bit (sums[i]),
            .c_out   (carry[i+1])
        );
    end

    alu_sign_fix u_sign (
        .msb_sum   (sums[MSB]),
        .msb_c_in  (carry[MSB]),
        .msb_c_out (carry[WIDTH]),
        .ovf       (overflow),
        .less_out  (set_bit)
    );

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .vec      (result),
        .all_zero (zero)
    );

    assign carry_out = carry[WIDTH];

endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             neg_b,
    input logic [1:0]       func_sel,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             overflow,
    input logic             carry_out
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   wide_add;
    logic [WIDTH:0]   wide_sub;
    logic             add_ovf;
    logic             sub_ovf;
    logic             lt_signed;

    always_comb begin
        wide_add  = {1'b0, opnd_a} + {1'b0, opnd_b};
        wide_sub  = {1'b0, opnd_a} + {1'b0, ~opnd_b} + {{WIDTH{1'b0}}, 1'b1};
        add_ovf   = (opnd_a[MSB] == opnd_b[MSB]) && (wide_add[MSB] != opnd_a[MSB]);
        sub_ovf   = (opnd_a[MSB] != opnd_b[MSB]) && (wide_sub[MSB] != opnd_a[MSB]);
        lt_signed = $signed(opnd_a) < $signed(opnd_b);
    end

    always_comb begin
        // R1
        and_result_chk: assert (!({neg_b, func_sel} == 3'b000) || result == (opnd_a & opnd_b));
        // R2
        or_result_chk: assert (!({neg_b, func_sel} == 3'b001) || result == (opnd_a | opnd_b));
        // R3
        add_result_chk: assert (!({neg_b, func_sel} == 3'b010) ||
                                (result == wide_add[MSB:0] && carry_out == wide_add[WIDTH]));
        // R4
        sub_result_chk: assert (!({neg_b, func_sel} == 3'b110) ||
                                (result == wide_sub[MSB:0] && carry_out == wide_sub[WIDTH]));
        // R5
        less_result_chk: assert (!({neg_b, func_sel} == 3'b111) ||
                                 result == {{(WIDTH-1){1'b0}}, lt_signed});
        // R6
        zero_flag_chk: assert (zero == (result == '0));
        // R7
        add_overflow_chk: assert (!({neg_b, func_sel} == 3'b010) || overflow == add_ovf);
        // R7
        sub_overflow_chk: assert (!({neg_b, func_sel} == 3'b110) || overflow == sub_ovf);
        // R8
        logic_flags_chk: assert (!(neg_b == 1'b0 && func_sel[1] == 1'b0) ||
                                 (carry_out == wide_add[WIDTH] && overflow == add_ovf));
    end

endmodule

bind slice_alu slice_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .neg_b     (neg_b),
    .func_sel  (func_sel),
    .result    (result),
    .zero      (zero),
    .overflow  (overflow),
    .carry_out (carry_out)
);

// File: tb/slice_alu_tb.sv
module slice_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a, b;
    logic        neg;
    logic [1:0]  fn;
    logic [31:0] result;
    logic        zero, overflow, carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    slice_alu u_dut (
        .opnd_a    (a),
        .opnd_b    (b),
        .neg_b     (neg),
        .func_sel  (fn),
        .result    (result),
        .zero      (zero),
        .overflow  (overflow),
        .carry_out (carry_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h (a=%h b=%h ctl=%b%b)",
                     req, what, got, exp, a, b, neg, fn);
        end
    endtask

    task automatic apply(input logic [31:0] ta, input logic [31:0] tb_v,
                         input logic tn, input logic [1:0] tf);
        logic [32:0] s_add, s_sub;
        logic [31:0] exp_r;
        logic        a_ovf, s_ovf, lt;
        @(negedge clk);
        a = ta; b = tb_v; neg = tn; fn = tf;
        #1;
        s_add = {1'b0, ta} + {1'b0, tb_v};
        s_sub = {1'b0, ta} + {1'b0, ~tb_v} + 33'd1;
        a_ovf = (ta[31] == tb_v[31]) && (s_add[31] != ta[31]);
        s_ovf = (ta[31] != tb_v[31]) && (s_sub[31] != ta[31]);
        lt    = $signed(ta) < $signed(tb_v);
        case ({tn, tf})
            3'b000: begin
                exp_r = ta & tb_v;
                check("R1", "and result", result, exp_r);
                check("R8", "and carry", {31'd0, carry_out}, {31'd0, s_add[32]});
                check("R8", "and overflow", {31'd0, overflow}, {31'd0, a_ovf});
            end
            3'b001: begin
                exp_r = ta | tb_v;
                check("R2", "or result", result, exp_r);
                check("R8", "or carry", {31'd0, carry_out}, {31'd0, s_add[32]});
            end
            3'b010: begin
                exp_r = s_add[31:0];
                check("R3", "add result", result, exp_r);
                check("R3", "add carry", {31'd0, carry_out}, {31'd0, s_add[32]});
                check("R7", "add overflow", {31'd0, overflow}, {31'd0, a_ovf});
            end
            3'b110: begin
                exp_r = s_sub[31:0];
                check("R4", "sub result", result, exp_r);
                check("R4", "sub carry", {31'd0, carry_out}, {31'd0, s_sub[32]});
                check("R7", "sub overflow", {31'd0, overflow}, {31'd0, s_ovf});
            end
            default: begin
                exp_r = {31'd0, lt};
                check("R5", "less result", result, exp_r);
            end
        endcase
        check("R6", "zero flag", {31'd0, zero}, {31'd0, (exp_r == 32'd0)});
    endtask

    task automatic test_reset_state();
        @(negedge clk);
        check("R6", "reset result", result, 32'd0);
        check("R6", "reset zero", {31'd0, zero}, 32'd1);
    endtask

    task automatic test_logic();
        apply(32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 2'b00);   // R1
        apply(32'hAAAA_5555, 32'h5555_AAAA, 1'b0, 2'b00);   // R1 all-zero result
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 2'b00);   // R8 carry with logic op
        apply(32'hF0F0_0000, 32'h000F_0F0F, 1'b0, 2'b01);   // R2
        apply(32'h0000_0000, 32'h0000_0000, 1'b0, 2'b01);   // R2 zero
    endtask

    task automatic test_add();
        apply(32'd12, 32'd30, 1'b0, 2'b10);                 // R3
        apply(32'h7FFF_FFFF, 32'd1, 1'b0, 2'b10);           // R7 positive overflow
        apply(32'h8000_0000, 32'h8000_0000, 1'b0, 2'b10);   // R7 negative overflow, zero
        apply(32'hFFFF_FFFF, 32'd1, 1'b0, 2'b10);           // R3 carry, R6 zero
    endtask

    task automatic test_sub();
        apply(32'd100, 32'd58, 1'b0 ^ 1'b1, 2'b10);         // R4
        apply(32'd5, 32'd5, 1'b1, 2'b10);                   // R4 zero result
        apply(32'd3, 32'd9, 1'b1, 2'b10);                   // R4 borrow
        apply(32'h8000_0000, 32'd1, 1'b1, 2'b10);           // R7 overflow
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 2'b10);   // R7 overflow
    endtask

    task automatic test_less();
        apply(32'd1, 32'd2, 1'b1, 2'b11);                   // R5
        apply(32'd2, 32'd1, 1'b1, 2'b11);                   // R5
        apply(32'hFFFF_FFFF, 32'd0, 1'b1, 2'b11);           // R5 -1 < 0
        apply(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 2'b11);   // R5 overflowing compare
        apply(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 2'b11);   // R5 overflowing compare
        apply(32'h8000_0000, 32'h8000_0000, 1'b1, 2'b11);   // R5 equal
    endtask

    task automatic test_random();
        logic [31:0] corner [4] = '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 32'h7FFF_FFFF};
        logic [2:0]  codes  [5] = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111};
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                for (int k = 0; k < 5; k++)
                    apply(corner[i], corner[j], codes[k][2], codes[k][1:0]);
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra = $urandom;
            logic [31:0] rb = $urandom;
            logic [2:0]  c  = codes[n % 5];
            apply(ra, rb, c[2], c[1:0]);
        end
    endtask

    initial begin
        a = '0; b = '0; neg = 1'b0; fn = 2'b00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        test_reset_state();
        test_logic();
        test_add();
        test_sub();
        test_less();
        test_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule